// File: doc/BRIEF.md
# Burst-Accumulating Converter Sequencer

This block is the digital controller that sits around a 10-bit successive-approximation converter. A convert start is taken from one selected source: the rising edge of an external pin, a software write, or a timer overflow pulse. Each accepted start runs the converter through an optional power-up wait, then tracking, then conversion. The block adds each result into a 16-bit sum. After a programmable number of samples has been summed, it hands the total to the system side. It then raises an interrupt pulse, sets a sticky end-of-conversion flag and gives a one-cycle valid strobe to a downstream window comparator.

The sequencer runs on its own fast clock, which also serves as the converter's SAR clock. The system side runs on a slower clock. A start crosses into the fast domain as a toggle through a two-stage synchronizer. The end of each job crosses back the same way. The summed result and the last-of-sequence marker are held stable in the fast domain until the system side has taken them. The configuration inputs are treated as static while a job is running.

In burst mode, one start runs the whole count of conversions back to back. Outside burst mode, each conversion needs its own start, and the sum carries from one start to the next until the count is complete. The converter is driven through four outputs: power, track, convert and a start-of-conversion strobe. Its sample is captured at the end of the conversion window.

Top module: `adc_burst_seq`

## Requirements
- R1: `acc_result` is the sum of the samples captured over one sequence. The repeat-count select `cfg_rpt` is encoded as 0=1, 1=4, 2=8, 3=16, 4=32, and 5 to 7 = 64 samples. The 16-bit sum cannot wrap.
- R2: With `cfg_burst`=1, one accepted start runs the full repeat count of conversions. With `cfg_burst`=0, each accepted start runs exactly one conversion.
- R3: `eoc_flag` and `eoc_irq` are raised only after the repeat count of conversions has been summed, never after an intermediate conversion.
- R4: `win_valid` pulses for exactly one system cycle per completed sequence, in the same cycle that `acc_result` takes the new sum.
- R5: While no job runs, `cv_pwr` equals `cfg_en`. With `cfg_burst`=1 and `cfg_en`=0, the converter is powered down after every burst. With `cfg_en`=1 it stays powered.
- R6: When a start arrives while the converter is unpowered, `cv_pwr` rises and exactly `cfg_pwrup` fast cycles pass before the first `cv_start` (a value of 0 counts as 1).
- R7: A conversion keeps `cv_conv` high for 14 fast cycles. With `cfg_dtrk`=0, back-to-back burst conversions start every 14 cycles. With `cfg_dtrk`=1, each conversion is preceded by 4 cycles of `cv_track`, giving 18 cycles per sample.
- R8: `busy` is high from the accepted start until the job completes. A start that arrives while `busy` is high is ignored.
- R9: On completion of a sequence, `eoc_irq` pulses for one cycle and `eoc_flag` is set. `eoc_flag` stays set until a `flag_clr` pulse.
- R10: `cfg_src` selects the start source: 0 = `sw_start` pulse, 1 = rising edge of `pin_cnvst`, 2 = `tmr_ovf` pulse, 3 = none. Events from sources that are not selected have no effect.
- R11: With `cfg_burst`=0 and `cfg_en`=0, starts are ignored.
- R12: The sum restarts at the first conversion of each new sequence, so a one-sample sequence reports that sample alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain reset, active low |
| fclk | input | 1 | Fast sequencer clock, also the SAR clock |
| frst_n | input | 1 | Fast-domain reset, active low |
| cfg_en | input | 1 | Converter enable; selects the idle power state |
| cfg_burst | input | 1 | Burst mode select |
| cfg_dtrk | input | 1 | Delayed-tracking mode select |
| cfg_rpt | input | 3 | Repeat-count select |
| cfg_pwrup | input | PWR_W | Power-up wait in fast cycles |
| cfg_src | input | 2 | Start source select |
| sw_start | input | 1 | Software start pulse |
| pin_cnvst | input | 1 | External start pin (asynchronous) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| flag_clr | input | 1 | Clears the sticky flag |
| busy | output | 1 | Job in progress |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| eoc_irq | output | 1 | One-cycle interrupt pulse |
| win_valid | output | 1 | Result-valid strobe for the comparator |
| acc_result | output | ACC_W | Summed result of the last sequence |
| cv_pwr | output | 1 | Converter power on |
| cv_track | output | 1 | Converter tracking |
| cv_conv | output | 1 | Converter conversion window |
| cv_start | output | 1 | First cycle of each conversion |
| cv_data | input | SMP_W | Sample from the converter |

## Verification
A wrong sample counter shows up at the converter pins within one sample. Too many or too few `cv_start` strobes appear before the job ends, and `acc_result` then differs from the sum of the delivered samples a few system cycles after `busy` falls. A phase counter that is off by even one cycle changes the spacing of `cv_start` in a burst, or the length of the power-up gap. Both are measured at the pins on every conversion. A bad handshake or bad gating shows as `busy` that never falls, as an extra interrupt, or as a conversion run on an ignored or masked start. Each of these is visible within tens of system cycles.

// File: rtl/abs_pkg.sv
package abs_pkg;

  localparam int RPT_W = 7;

  localparam logic [1:0] SRC_SW  = 2'd0;
  localparam logic [1:0] SRC_PIN = 2'd1;
  localparam logic [1:0] SRC_TMR = 2'd2;
  localparam logic [1:0] SRC_OFF = 2'd3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PWRUP = 2'd1,
    SQ_TRACK = 2'd2,
    SQ_CONV  = 2'd3
  } seq_state_e;

  // samples per sequence for a given select code
  function automatic logic [RPT_W-1:0] rpt_decode(input logic [2:0] sel);
    case (sel)
      3'd0:    return 7'd1;
      3'd1:    return 7'd4;
      3'd2:    return 7'd8;
      3'd3:    return 7'd16;
      3'd4:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  // running-sum update: the first sample of a sequence replaces the sum
  function automatic logic [31:0] acc_add(input logic [31:0] acc,
                                          input logic [31:0] smp,
                                          input logic        first);
    return first ? smp : (acc + smp);
  endfunction

  // phase entered after a start or between burst samples
  function automatic seq_state_e first_phase(input logic dtrk);
    return dtrk ? SQ_TRACK : SQ_CONV;
  endfunction

endpackage

// File: rtl/abs_sync2.sv
module abs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/abs_trig.sv
module abs_trig
  import abs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_src,
  input  logic       cfg_en,
  input  logic       cfg_burst,
  input  logic       sw_start,
  input  logic       pin_cnvst,
  input  logic       tmr_ovf,
  input  logic       busy,
  output logic       start_ok
);
  logic pin_s;
  logic pin_d;
  logic pin_rise;
  logic src_evt;
  logic mode_ok;

  abs_sync2 u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_cnvst),
    .q     (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= 1'b0;
    else        pin_d <= pin_s;
  end

  assign pin_rise = pin_s & ~pin_d;

  always_comb begin
    case (cfg_src)
      SRC_SW:  src_evt = sw_start;
      SRC_PIN: src_evt = pin_rise;
      SRC_TMR: src_evt = tmr_ovf;
      default: src_evt = 1'b0;
    endcase
  end

  // single conversions need the converter enabled; bursts wake it themselves
  assign mode_ok  = cfg_burst | cfg_en;
  assign start_ok = src_evt & ~busy & mode_ok;

  AST_PIN_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise); // R10

endmodule

// File: rtl/abs_sysif.sv
module abs_sysif #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             flag_clr,
  output logic             req_tgl,
  input  logic             done_tgl_f,
  input  logic             job_last_f,
  input  logic [ACC_W-1:0] acc_f,
  output logic             busy,
  output logic             eoc_flag,
  output logic             eoc_irq,
  output logic             win_valid,
  output logic [ACC_W-1:0] acc_result
);
  logic done_s;
  logic done_d;
  logic done_evt;
  logic seq_done;

  abs_sync2 u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (done_tgl_f),
    .q     (done_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_d <= 1'b0;
    else        done_d <= done_s;
  end

  assign done_evt = done_s ^ done_d;
  assign seq_done = done_evt & job_last_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      req_tgl    <= 1'b0;
      eoc_irq    <= 1'b0;
      win_valid  <= 1'b0;
      acc_result <= '0;
    end else begin
      eoc_irq   <= 1'b0;
      win_valid <= 1'b0;
      if (start_ok) begin
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
      end
      if (done_evt) begin
        busy <= 1'b0;
      end
      if (seq_done) begin
        acc_result <= acc_f;
        eoc_irq    <= 1'b1;
        win_valid  <= 1'b1;
      end
    end
  end

  // sticky flag: a completion in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eoc_flag <= 1'b0;
    else if (seq_done) eoc_flag <= 1'b1;
    else if (flag_clr) eoc_flag <= 1'b0;
  end

  AST_BUSY_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt)); // R8

  AST_WIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> !win_valid); // R4

  AST_FLAG_RISE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_flag) |-> eoc_irq); // R9

endmodule

// File: rtl/abs_seq.sv
module abs_seq
  import abs_pkg::*;
#(
  parameter int SMP_W      = 10,
  parameter int ACC_W      = 16,
  parameter int PWR_W      = 5,
  parameter int CONV_CLKS  = 14,
  parameter int TRACK_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl_s,
  input  logic             cfg_en,
  input  logic             cfg_burst,
  input  logic             cfg_dtrk,
  input  logic [2:0]       cfg_rpt,
  input  logic [PWR_W-1:0] cfg_pwrup,
  input  logic [SMP_W-1:0] cv_data,
  output logic             cv_pwr,
  output logic             cv_track,
  output logic             cv_conv,
  output logic             cv_start,
  output logic             done_tgl,
  output logic             job_last,
  output logic [ACC_W-1:0] acc_hold
);
  localparam int PH_MAX = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] CONV_LAST  = PH_W'(CONV_CLKS - 1);
  localparam logic [PH_W-1:0] TRACK_LAST = PH_W'(TRACK_CLKS - 1);

  seq_state_e       state;
  logic [PH_W-1:0]  ph_cnt;
  logic [PWR_W-1:0] wait_cnt;
  logic [RPT_W-1:0] smp_cnt;
  logic [ACC_W-1:0] acc;

  logic             req_d;
  logic             start_p;
  logic [RPT_W-1:0] rpt;
  logic             conv_end;
  logic             trk_end;
  logic             pw_end;
  logic             seq_last;
  logic             first_smp;
  logic [ACC_W-1:0] acc_next;
  seq_state_e       entry_ph;

  // start request from the system side arrives as a toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_tgl_s;
  end
  assign start_p = req_tgl_s ^ req_d;

  assign rpt       = rpt_decode(cfg_rpt);
  assign entry_ph  = first_phase(cfg_dtrk);
  assign conv_end  = (state == SQ_CONV)  && (ph_cnt == CONV_LAST);
  assign trk_end   = (state == SQ_TRACK) && (ph_cnt == TRACK_LAST);
  assign pw_end    = (state == SQ_PWRUP) && (wait_cnt <= PWR_W'(1));
  assign first_smp = (smp_cnt == '0);
  assign seq_last  = conv_end && (smp_cnt >= (rpt - 7'd1));
  assign acc_next  = ACC_W'(acc_add(32'(acc), 32'(cv_data), first_smp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ph_cnt   <= '0;
      wait_cnt <= '0;
      smp_cnt  <= '0;
      acc      <= '0;
      acc_hold <= '0;
      job_last <= 1'b0;
      done_tgl <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_p) begin
            ph_cnt <= '0;
            if (!cfg_en) begin
              state    <= SQ_PWRUP;
              wait_cnt <= cfg_pwrup;
            end else begin
              state <= entry_ph;
            end
          end
        end
        SQ_PWRUP: begin
          if (pw_end) begin
            state  <= entry_ph;
            ph_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt - PWR_W'(1);
          end
        end
        SQ_TRACK: begin
          if (trk_end) begin
            state  <= SQ_CONV;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        SQ_CONV: begin
          if (conv_end) begin
            acc    <= acc_next;
            ph_cnt <= '0;
            if (seq_last) begin
              smp_cnt  <= '0;
              acc_hold <= acc_next;
              job_last <= 1'b1;
              done_tgl <= ~done_tgl;
              state    <= SQ_IDLE;
            end else begin
              smp_cnt <= smp_cnt + 7'd1;
              if (cfg_burst) begin
                state <= entry_ph;
              end else begin
                job_last <= 1'b0;
                done_tgl <= ~done_tgl;
                state    <= SQ_IDLE;
              end
            end
          end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cv_pwr   = (state != SQ_IDLE) || cfg_en;
  assign cv_conv  = (state == SQ_CONV);
  assign cv_start = (state == SQ_CONV) && (ph_cnt == '0);
  assign cv_track = (state == SQ_TRACK) ||
                    (!cfg_dtrk && cv_pwr && (state != SQ_CONV) && (state != SQ_PWRUP));

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && !first_smp) |-> (acc_next >= acc)); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_IDLE) |-> (smp_cnt < rpt)); // R2

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> (state == SQ_IDLE)); // R8

  AST_TRACK_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dtrk && cv_start) |-> ($past(state) == SQ_TRACK)); // R7

  AST_PWRUP_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cv_pwr) && !cfg_en) |-> (state == SQ_PWRUP)); // R6

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int SMP_W      = 10,
  parameter int ACC_W      = 16,
  parameter int PWR_W      = 5,
  parameter int CONV_CLKS  = 14,
  parameter int TRACK_CLKS = 4
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             fclk,
  input  logic             frst_n,
  input  logic             cfg_en,
  input  logic             cfg_burst,
  input  logic             cfg_dtrk,
  input  logic [2:0]       cfg_rpt,
  input  logic [PWR_W-1:0] cfg_pwrup,
  input  logic [1:0]       cfg_src,
  input  logic             sw_start,
  input  logic             pin_cnvst,
  input  logic             tmr_ovf,
  input  logic             flag_clr,
  output logic             busy,
  output logic             eoc_flag,
  output logic             eoc_irq,
  output logic             win_valid,
  output logic [ACC_W-1:0] acc_result,
  output logic             cv_pwr,
  output logic             cv_track,
  output logic             cv_conv,
  output logic             cv_start,
  input  logic [SMP_W-1:0] cv_data
);
  logic             start_ok;
  logic             req_tgl;
  logic             req_tgl_s;
  logic             done_tgl;
  logic             job_last;
  logic [ACC_W-1:0] acc_hold;

  abs_trig u_trig (
    .clk       (sys_clk),
    .rst_n     (sys_rst_n),
    .cfg_src   (cfg_src),
    .cfg_en    (cfg_en),
    .cfg_burst (cfg_burst),
    .sw_start  (sw_start),
    .pin_cnvst (pin_cnvst),
    .tmr_ovf   (tmr_ovf),
    .busy      (busy),
    .start_ok  (start_ok)
  );

  abs_sysif #(.ACC_W(ACC_W)) u_sysif (
    .clk        (sys_clk),
    .rst_n      (sys_rst_n),
    .start_ok   (start_ok),
    .flag_clr   (flag_clr),
    .req_tgl    (req_tgl),
    .done_tgl_f (done_tgl),
    .job_last_f (job_last),
    .acc_f      (acc_hold),
    .busy       (busy),
    .eoc_flag   (eoc_flag),
    .eoc_irq    (eoc_irq),
    .win_valid  (win_valid),
    .acc_result (acc_result)
  );

  abs_sync2 u_req_sync (
    .clk   (fclk),
    .rst_n (frst_n),
    .d     (req_tgl),
    .q     (req_tgl_s)
  );

  abs_seq #(
    .SMP_W      (SMP_W),
    .ACC_W      (ACC_W),
    .PWR_W      (PWR_W),
    .CONV_CLKS  (CONV_CLKS),
    .TRACK_CLKS (TRACK_CLKS)
  ) u_seq (
    .clk       (fclk),
    .rst_n     (frst_n),
    .req_tgl_s (req_tgl_s),
    .cfg_en    (cfg_en),
    .cfg_burst (cfg_burst),
    .cfg_dtrk  (cfg_dtrk),
    .cfg_rpt   (cfg_rpt),
    .cfg_pwrup (cfg_pwrup),
    .cv_data   (cv_data),
    .cv_pwr    (cv_pwr),
    .cv_track  (cv_track),
    .cv_conv   (cv_conv),
    .cv_start  (cv_start),
    .done_tgl  (done_tgl),
    .job_last  (job_last),
    .acc_hold  (acc_hold)
  );

endmodule

// File: tb/tb_adc_burst_seq.sv
`timescale 1ns/100ps
module tb_adc_burst_seq;
  logic        sys_clk = 1'b0;
  logic        fclk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        frst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_burst = 1'b0;
  logic        cfg_dtrk = 1'b0;
  logic [2:0]  cfg_rpt = 3'd0;
  logic [4:0]  cfg_pwrup = 5'd0;
  logic [1:0]  cfg_src = 2'd0;
  logic        sw_start = 1'b0;
  logic        pin_cnvst = 1'b0;
  logic        tmr_ovf = 1'b0;
  logic        flag_clr = 1'b0;
  logic        busy, eoc_flag, eoc_irq, win_valid;
  logic [15:0] acc_result;
  logic        cv_pwr, cv_track, cv_conv, cv_start;
  logic [9:0]  cv_data = 10'd0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // monitor state (written only by the monitors)
  int fcyc = 0, last_t = 0, vk = 0;
  bit have_prev = 1'b0;
  int n_conv = 0, sum_total = 0;
  int job_conv = 0, job_sum = 0, ivl_min = 0, ivl_max = 0;
  int trk_run = 0, trk_last = 0;
  int pw_run = 0, pw_meas = 0;
  bit pw_armed = 1'b0;
  int n_irq = 0, n_win = 0, busy_seen = 0;

  adc_burst_seq dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .fclk(fclk), .frst_n(frst_n),
    .cfg_en(cfg_en), .cfg_burst(cfg_burst), .cfg_dtrk(cfg_dtrk),
    .cfg_rpt(cfg_rpt), .cfg_pwrup(cfg_pwrup), .cfg_src(cfg_src),
    .sw_start(sw_start), .pin_cnvst(pin_cnvst), .tmr_ovf(tmr_ovf),
    .flag_clr(flag_clr), .busy(busy), .eoc_flag(eoc_flag), .eoc_irq(eoc_irq),
    .win_valid(win_valid), .acc_result(acc_result), .cv_pwr(cv_pwr),
    .cv_track(cv_track), .cv_conv(cv_conv), .cv_start(cv_start),
    .cv_data(cv_data)
  );

  always #10 sys_clk = ~sys_clk;
  always #3.5 fclk = ~fclk;

  // converter model and timing monitor on the fast clock
  always @(negedge fclk) begin
    int val;
    fcyc = fcyc + 1;
    if (cv_start) begin
      val = (vk * 97 + 13) % 1024;
      vk = vk + 1;
      cv_data = val[9:0];
      n_conv = n_conv + 1;
      sum_total = sum_total + val;
      if (!have_prev || (fcyc - last_t) > 30) begin
        job_conv = 1; job_sum = val; ivl_min = 9999; ivl_max = 0;
      end else begin
        job_conv = job_conv + 1;
        job_sum = job_sum + val;
        if ((fcyc - last_t) < ivl_min) ivl_min = fcyc - last_t;
        if ((fcyc - last_t) > ivl_max) ivl_max = fcyc - last_t;
      end
      have_prev = 1'b1;
      last_t = fcyc;
      trk_last = trk_run;
    end
    if (cv_track) trk_run = trk_run + 1;
    else          trk_run = 0;
    if (!cv_pwr) begin
      pw_run = 0; pw_armed = 1'b1;
    end else if (cv_start) begin
      if (pw_armed) pw_meas = pw_run;
      pw_armed = 1'b0;
    end else if (pw_armed) begin
      pw_run = pw_run + 1;
    end
  end

  always @(negedge sys_clk) begin
    if (eoc_irq)   n_irq = n_irq + 1;
    if (win_valid) n_win = n_win + 1;
    if (busy)      busy_seen = busy_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sys_cycles(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic fire(input int src);
    @(negedge sys_clk);
    case (src)
      0: begin sw_start = 1'b1; @(negedge sys_clk); sw_start = 1'b0; end
      1: begin pin_cnvst = 1'b1; sys_cycles(4); pin_cnvst = 1'b0; end
      default: begin tmr_ovf = 1'b1; @(negedge sys_clk); tmr_ovf = 1'b0; end
    endcase
  endtask

  task automatic clear_flag();
    @(negedge sys_clk); flag_clr = 1'b1;
    @(negedge sys_clk); flag_clr = 1'b0;
    sys_cycles(1);
  endtask

  // start one job and wait for busy to fall
  task automatic run_job(input int src, input string req);
    int t;
    fire(src);
    t = 0;
    while (!busy && t < 20) begin @(negedge sys_clk); t++; end
    chk(busy, req, "busy after start", busy, 1);
    t = 0;
    while (busy && t < 5000) begin @(negedge sys_clk); t++; end
    chk(!busy, req, "busy falls at completion", busy, 0);
    sys_cycles(40);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R8", "reset busy", busy, 0);
    chk(eoc_flag == 1'b0, "R9", "reset flag", eoc_flag, 0);
    chk(acc_result == 16'd0, "R1", "reset result", acc_result, 0);
    chk(cv_pwr == 1'b0, "R5", "reset power with enable low", cv_pwr, 0);
    chk(cv_conv == 1'b0, "R7", "reset conv", cv_conv, 0);
  endtask

  task automatic t_burst_cont();
    int irq0, win0;
    cfg_en = 1; cfg_burst = 1; cfg_dtrk = 0; cfg_rpt = 3'd1; cfg_src = 2'd0;
    sys_cycles(2);
    chk(cv_pwr == 1'b1, "R5", "idle powered with enable", cv_pwr, 1);
    irq0 = n_irq; win0 = n_win;
    run_job(0, "R2");
    chk(job_conv == 4, "R2", "burst of 4 conversions", job_conv, 4);
    chk(acc_result == job_sum[15:0], "R1", "sum of 4", acc_result, job_sum);
    chk(ivl_min == 14 && ivl_max == 14, "R7", "14-cycle spacing", ivl_max, 14);
    chk(n_irq - irq0 == 1, "R3", "one irq per sequence", n_irq - irq0, 1);
    chk(n_win - win0 == 1, "R4", "one valid strobe", n_win - win0, 1);
    chk(eoc_flag == 1'b1, "R9", "flag set", eoc_flag, 1);
    chk(cv_pwr == 1'b1, "R5", "stays powered after burst", cv_pwr, 1);
  endtask

  task automatic t_flag_clr();
    clear_flag();
    chk(eoc_flag == 1'b0, "R9", "flag cleared by write", eoc_flag, 0);
  endtask

  task automatic t_burst_delayed();
    cfg_en = 1; cfg_burst = 1; cfg_dtrk = 1; cfg_rpt = 3'd5; cfg_src = 2'd2;
    sys_cycles(2);
    run_job(2, "R10");
    chk(job_conv == 64, "R2", "burst of 64 via timer", job_conv, 64);
    chk(acc_result == job_sum[15:0], "R1", "sum of 64", acc_result, job_sum);
    chk(ivl_min == 18 && ivl_max == 18, "R7", "18-cycle spacing", ivl_min, 18);
    chk(trk_last == 4, "R7", "track window", trk_last, 4);
  endtask

  task automatic t_burst_pwrdn();
    cfg_en = 0; cfg_burst = 1; cfg_dtrk = 0; cfg_rpt = 3'd2; cfg_pwrup = 5'd10;
    cfg_src = 2'd1;
    sys_cycles(2);
    chk(cv_pwr == 1'b0, "R5", "idle unpowered", cv_pwr, 0);
    run_job(1, "R10");
    chk(job_conv == 8, "R2", "burst of 8 via pin", job_conv, 8);
    chk(acc_result == job_sum[15:0], "R1", "sum of 8", acc_result, job_sum);
    chk(pw_meas == 10, "R6", "power-up wait", pw_meas, 10);
    chk(cv_pwr == 1'b0, "R5", "powered down after burst", cv_pwr, 0);
  endtask

  task automatic t_single();
    cfg_en = 1; cfg_burst = 1; cfg_dtrk = 0; cfg_rpt = 3'd0; cfg_src = 2'd0;
    sys_cycles(2);
    run_job(0, "R12");
    chk(job_conv == 1, "R12", "one conversion", job_conv, 1);
    chk(acc_result == job_sum[15:0], "R12", "sum restarts", acc_result, job_sum);
  endtask

  task automatic t_nonburst();
    int irq0, c0, s0;
    cfg_en = 1; cfg_burst = 0; cfg_dtrk = 0; cfg_rpt = 3'd1; cfg_src = 2'd0;
    clear_flag();
    irq0 = n_irq; c0 = n_conv; s0 = sum_total;
    for (int i = 0; i < 4; i++) begin
      run_job(0, "R2");
      chk(n_conv - c0 == i + 1, "R2", "one conversion per start", n_conv - c0, i + 1);
      if (i < 3) begin
        chk(eoc_flag == 1'b0, "R3", "no flag mid-sequence", eoc_flag, 0);
        chk(n_irq == irq0, "R3", "no irq mid-sequence", n_irq - irq0, 0);
      end
    end
    chk(eoc_flag == 1'b1, "R3", "flag after 4th", eoc_flag, 1);
    chk(n_irq - irq0 == 1, "R3", "single irq", n_irq - irq0, 1);
    chk(acc_result == 16'(sum_total - s0), "R1", "sum across starts", acc_result, sum_total - s0);
  endtask

  task automatic t_ignore_busy();
    int irq0, t, b0;
    cfg_en = 1; cfg_burst = 1; cfg_dtrk = 0; cfg_rpt = 3'd4; cfg_src = 2'd0;
    sys_cycles(2);
    irq0 = n_irq;
    fire(0);
    sys_cycles(20);
    chk(busy == 1'b1, "R8", "busy mid-burst", busy, 1);
    fire(0);
    t = 0;
    while (busy && t < 5000) begin @(negedge sys_clk); t++; end
    sys_cycles(40);
    chk(job_conv == 32, "R8", "extra start ignored", job_conv, 32);
    chk(n_irq - irq0 == 1, "R8", "one completion", n_irq - irq0, 1);
    b0 = busy_seen;
    sys_cycles(30);
    chk(busy_seen == b0, "R8", "no queued job", busy_seen - b0, 0);
  endtask

  task automatic t_src_mask();
    int b0, c0;
    cfg_en = 1; cfg_burst = 1; cfg_rpt = 3'd0; cfg_src = 2'd0;
    b0 = busy_seen; c0 = n_conv;
    fire(2); fire(1);
    sys_cycles(30);
    chk(busy_seen == b0 && n_conv == c0, "R10", "unselected sources", n_conv - c0, 0);
    cfg_src = 2'd3;
    fire(0);
    sys_cycles(30);
    chk(busy_seen == b0 && n_conv == c0, "R10", "source off", n_conv - c0, 0);
  endtask

  task automatic t_nb_disabled();
    int b0, c0;
    cfg_en = 0; cfg_burst = 0; cfg_src = 2'd0;
    b0 = busy_seen; c0 = n_conv;
    fire(0);
    sys_cycles(30);
    chk(busy_seen == b0 && n_conv == c0, "R11", "disabled single start", n_conv - c0, 0);
  endtask

  initial begin
    sys_cycles(3);
    sys_rst_n = 1'b1; frst_n = 1'b1;
    sys_cycles(3);
    t_reset();
    t_burst_cont();
    t_flag_clr();
    t_burst_delayed();
    t_burst_pwrdn();
    t_single();
    t_nonburst();
    t_ignore_busy();
    t_src_mask();
    t_nb_disabled();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule